// File: doc/BRIEF.md
# Wide Register Access Collector

This unit sits between a host port that moves one 32-bit dword per request and a register file whose control registers are 128 bits wide. Each register has four dwords, at byte offsets 0, 4, 8 and 12. The unit also serves a memory window of 64-bit words. The unit keeps wide accesses atomic. Partial writes gather in a collector, and the register file sees only one full-width commit. A read of the lowest dword, or of a register other than the one held, captures the whole register into a snapshot. Later reads of the higher dwords are answered from that snapshot. Two write-only doorbell registers in every 0x2000-byte page commit as soon as their top dword is written. Per-page 32-bit registers bypass both the collector and the snapshot.

The write path is a two-state machine, `COL_EMPTY` and `COL_FILLING`.
- A write to a wide register or a memory word moves `COL_EMPTY -> COL_FILLING` (start).
- While filling, a write to the same register adds a dword (gather).
- While filling, a write to another register starts over for that register (restart).
- The write that completes the set of dwords goes `-> COL_EMPTY` (commit).
- A doorbell top-dword write that uses the held data goes `COL_FILLING -> COL_EMPTY` (ring).
- A doorbell low-dword write that would disturb a different register stays in `COL_FILLING` (drop).

The read path has two states, `SNAP_NONE` and `SNAP_HELD`.
- A fetching read of a wide register or a memory word goes `SNAP_NONE -> SNAP_HELD` (capture).
- Any later fetch goes `SNAP_HELD -> SNAP_HELD` and replaces the snapshot (recapture).
- A read served from the snapshot goes `SNAP_HELD -> SNAP_HELD` (reuse).

Top module: `wide_reg_collector`

## Requirements
- R1: After reset the collector is empty and no snapshot is held. `rf_we`, `rf_re` and `host_rvalid` are low. The first read of any dword then fetches from the register file.
- R2: Writes to the four dwords of a wide register may come in any order. The first three give no `rf_we`. The fourth gives exactly one `rf_we` cycle with the 16-byte aligned `rf_addr`, `rf_size` = 2, and all four dwords in `rf_wdata` (dword n at bits 32n+31:32n).
- R3: A write to a different register while the collector is filling discards the dwords gathered so far. Collection then restarts with the new dword.
- R4: Addresses at or above `MEM_BASE` are 64-bit words. Two halves are gathered (offset 0 = low, offset 4 = high). One commit follows with the 8-byte aligned address, `rf_size` = 1, and bits 127:64 zero.
- R5: A read of dword 0 of a wide register, or of any dword of a register other than the held one, asserts `rf_re` with the aligned address. The same cycle captures all 128 bits. The requested dword appears on `host_rdata` with `host_rvalid` one cycle later.
- R6: A read of dword 1, 2 or 3 of the held register gives no `rf_re`. It returns the snapshot value even if the live register has changed.
- R7: Memory-window reads follow R5 and R6 with two halves: offset 0 fetches and the high half reuses the snapshot.
- R8: A write to the top dword of a doorbell commits at once. The doorbells sit at page offsets 0x830 and 0xa10, with top dwords at 0x83c and 0xa1c. The low three dwords come from the collector when it holds that doorbell and are zero otherwise. A collection for another register survives this commit.
- R9: A write to a non-top dword of a doorbell is discarded while the collector holds a different register. The held address, mask and data are kept.
- R10: The 32-bit register at page offset 0x400 writes at once, with `rf_size` = 0 and `rf_wdata` = {96'b0, data}. It reads at once through `rf_re`. Neither access changes the collector or the snapshot.
- R11: Register offsets repeat in every 0x2000-byte page. The decode uses only the address bits below the page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host request valid for one cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte address of the dword |
| host_wdata | input | 32 | Write dword |
| host_rdata | output | 32 | Read dword, registered |
| host_rvalid | output | 1 | Read data valid, one cycle after a read request |
| rf_we | output | 1 | Register-file commit strobe |
| rf_re | output | 1 | Register-file fetch strobe |
| rf_addr | output | ADDR_W | Aligned base address of the accessed register |
| rf_size | output | 2 | 0 = 32-bit, 1 = 64-bit, 2 = 128-bit |
| rf_wdata | output | 128 | Commit data |
| rf_rdata | input | 128 | Register-file data for `rf_addr`, same cycle |

## Verification
Several corner cases are targeted, each with the fault it exposes:
- **Gathering.** Dwords are written out of order and interrupted by another register. A collector that commits early, or that merges stale dwords across a restart, shows a premature or wrong commit.
- **Snapshots.** The live register value changes between a capture and a later high-dword read. A unit that re-fetches returns the new value instead of the snapshot.
- **Doorbells.** They are rung with the collector empty, holding the same doorbell, and holding another register. Wrong zero-fill shows in the low 96 bits. A dropped low-dword write that leaks into the collector corrupts the pending register's commit.
- **Narrow registers and page decode.** These are checked on pages other than zero. A narrow access that disturbs the collector, or a decode that ignores the page offset, fails there.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
    typedef enum logic [1:0] {KIND_NARROW, KIND_WIDE, KIND_BELL, KIND_MEM} kind_e;
    typedef enum logic {COL_EMPTY, COL_FILLING} col_state_e;
    typedef enum logic {SNAP_NONE, SNAP_HELD} snap_state_e;
    localparam logic [1:0] SIZE32  = 2'd0;
    localparam logic [1:0] SIZE64  = 2'd1;
    localparam logic [1:0] SIZE128 = 2'd2;
endpackage

// File: rtl/wrc_decode.sv
module wrc_decode
    import wrc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 13,
    parameter logic [ADDR_W-1:0] MEM_BASE   = 16'hC000,
    parameter logic [PAGE_W-1:0] NARROW_OFF = 13'h400,
    parameter logic [PAGE_W-1:0] BELL_A     = 13'h830,
    parameter logic [PAGE_W-1:0] BELL_B     = 13'ha10
) (
    input  logic [ADDR_W-1:0] addr,
    output kind_e             kind,
    output logic [ADDR_W-1:0] base,
    output logic [1:0]        idx,
    output logic [1:0]        size
);
    logic [PAGE_W-1:0] off;
    assign off = addr[PAGE_W-1:0];

    always_comb begin
        if (addr >= MEM_BASE) begin
            kind = KIND_MEM;
            base = {addr[ADDR_W-1:3], 3'b0};
            idx  = {1'b0, addr[2]};
            size = SIZE64;
        end else if (off[PAGE_W-1:2] == NARROW_OFF[PAGE_W-1:2]) begin
            kind = KIND_NARROW;
            base = {addr[ADDR_W-1:2], 2'b0};
            idx  = 2'd0;
            size = SIZE32;
        end else begin
            kind = ((off[PAGE_W-1:4] == BELL_A[PAGE_W-1:4]) ||
                    (off[PAGE_W-1:4] == BELL_B[PAGE_W-1:4])) ? KIND_BELL : KIND_WIDE;
            base = {addr[ADDR_W-1:4], 4'b0};
            idx  = addr[3:2];
            size = SIZE128;
        end
    end
endmodule

// File: rtl/wrc_collector.sv
module wrc_collector
    import wrc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  kind_e             kind,
    input  logic [ADDR_W-1:0] base,
    input  logic [1:0]        idx,
    input  logic [31:0]       wdata,
    output logic              commit,
    output logic [127:0]      commit_data
);
    col_state_e        st_q, st_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic [3:0]        mask_q, mask_d;
    logic [3:0][31:0]  data_q, data_d;
    logic              same;
    logic [3:0]        held, next_mask;
    logic              full;

    assign same      = (st_q == COL_FILLING) && (base_q == base);
    assign held      = same ? mask_q : 4'b0;
    assign next_mask = held | (4'b1 << idx);
    assign full      = (kind == KIND_MEM) ? (next_mask[1:0] == 2'b11) : (&next_mask);

    always_comb begin
        st_d        = st_q;
        base_d      = base_q;
        mask_d      = mask_q;
        data_d      = data_q;
        commit      = 1'b0;
        commit_data = '0;
        if (wr_req) begin
            unique case (kind)
                KIND_NARROW: begin
                    commit      = 1'b1;
                    commit_data = {96'b0, wdata};
                end
                KIND_BELL: begin
                    if (idx == 2'd3) begin
                        commit = 1'b1;
                        for (int d = 0; d < 3; d++)
                            commit_data[d*32 +: 32] = held[d] ? data_q[d] : 32'b0;
                        commit_data[127:96] = wdata;
                        if (same) begin
                            st_d   = COL_EMPTY;
                            mask_d = 4'b0;
                        end
                    end else if (!((st_q == COL_FILLING) && !same)) begin
                        st_d        = COL_FILLING;
                        base_d      = base;
                        mask_d      = next_mask;
                        data_d[idx] = wdata;
                    end
                end
                KIND_WIDE, KIND_MEM: begin
                    if (full) begin
                        commit = 1'b1;
                        for (int d = 0; d < 4; d++) begin
                            if (kind == KIND_MEM && d >= 2)
                                commit_data[d*32 +: 32] = 32'b0;
                            else if (2'(d) == idx)
                                commit_data[d*32 +: 32] = wdata;
                            else
                                commit_data[d*32 +: 32] = data_q[d];
                        end
                        st_d   = COL_EMPTY;
                        mask_d = 4'b0;
                    end else begin
                        st_d        = COL_FILLING;
                        base_d      = base;
                        mask_d      = next_mask;
                        data_d[idx] = wdata;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= COL_EMPTY;
            base_q <= '0;
            mask_q <= '0;
            data_q <= '0;
        end else begin
            st_q   <= st_d;
            base_q <= base_d;
            mask_q <= mask_d;
            data_q <= data_d;
        end
    end

    // R2: a full-width commit leaves the collector empty
    p_commit_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && (kind == KIND_WIDE || kind == KIND_MEM)) |=> (st_q == COL_EMPTY && mask_q == 4'b0));
    // R9: a conflicting doorbell low-dword write leaves the collector as it was
    p_drop_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && kind == KIND_BELL && idx != 2'd3 && st_q == COL_FILLING && base_q != base)
        |=> ($stable(mask_q) && $stable(base_q) && $stable(data_q)));
    // R10: a narrow write does not touch the collector
    p_narrow_untouched_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && kind == KIND_NARROW) |=> ($stable(mask_q) && $stable(base_q) && $stable(data_q)));
endmodule

// File: rtl/wrc_snapshot.sv
module wrc_snapshot
    import wrc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  kind_e             kind,
    input  logic [ADDR_W-1:0] base,
    input  logic [1:0]        idx,
    input  logic [127:0]      rf_rdata,
    output logic              fetch,
    output logic [31:0]       rdata,
    output logic              rvalid
);
    snap_state_e       st_q;
    logic [ADDR_W-1:0] base_q;
    logic [127:0]      snap_q;
    logic              capture;

    assign fetch   = rd_req && ((kind == KIND_NARROW) || (idx == 2'd0) ||
                                (st_q != SNAP_HELD) || (base_q != base));
    assign capture = fetch && (kind != KIND_NARROW);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= SNAP_NONE;
            base_q <= '0;
            snap_q <= '0;
        end else if (capture) begin
            st_q   <= SNAP_HELD;
            base_q <= base;
            snap_q <= rf_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_req;
            if (rd_req)
                rdata <= fetch ? rf_rdata[{idx, 5'b0} +: 32] : snap_q[{idx, 5'b0} +: 32];
        end
    end

    // R5: every read returns data on the following cycle
    p_rvalid_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rvalid);
    // R6: a read answered from the snapshot leaves it unchanged
    p_reuse_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !fetch) |=> ($stable(snap_q) && $stable(base_q)));
endmodule

// File: rtl/wide_reg_collector.sv
module wide_reg_collector
    import wrc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 13,
    parameter logic [ADDR_W-1:0] MEM_BASE   = 16'hC000,
    parameter logic [PAGE_W-1:0] NARROW_OFF = 13'h400,
    parameter logic [PAGE_W-1:0] BELL_A     = 13'h830,
    parameter logic [PAGE_W-1:0] BELL_B     = 13'ha10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              host_rvalid,
    output logic              rf_we,
    output logic              rf_re,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [1:0]        rf_size,
    output logic [127:0]      rf_wdata,
    input  logic [127:0]      rf_rdata
);
    kind_e             kind;
    logic [ADDR_W-1:0] base;
    logic [1:0]        idx;

    wrc_decode #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .MEM_BASE(MEM_BASE),
        .NARROW_OFF(NARROW_OFF), .BELL_A(BELL_A), .BELL_B(BELL_B)
    ) u_decode (
        .addr(host_addr), .kind(kind), .base(base), .idx(idx), .size(rf_size)
    );

    wrc_collector #(.ADDR_W(ADDR_W)) u_collector (
        .clk(clk), .rst_n(rst_n), .wr_req(host_req && host_we),
        .kind(kind), .base(base), .idx(idx), .wdata(host_wdata),
        .commit(rf_we), .commit_data(rf_wdata)
    );

    wrc_snapshot #(.ADDR_W(ADDR_W)) u_snapshot (
        .clk(clk), .rst_n(rst_n), .rd_req(host_req && !host_we),
        .kind(kind), .base(base), .idx(idx), .rf_rdata(rf_rdata),
        .fetch(rf_re), .rdata(host_rdata), .rvalid(host_rvalid)
    );

    assign rf_addr = base;

    // R1: commit and fetch never share a cycle
    p_we_re_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we && rf_re));
endmodule

// File: tb/wide_reg_collector_bench.sv
module wide_reg_collector_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         host_req = 1'b0;
    logic         host_we = 1'b0;
    logic [15:0]  host_addr = '0;
    logic [31:0]  host_wdata = '0;
    logic [31:0]  host_rdata;
    logic         host_rvalid;
    logic         rf_we, rf_re;
    logic [15:0]  rf_addr;
    logic [1:0]   rf_size;
    logic [127:0] rf_wdata;
    logic [127:0] rf_rdata;
    logic [7:0]   key = 8'd0;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    logic         s_we, s_re;
    logic [15:0]  s_addr;
    logic [1:0]   s_size;
    logic [127:0] s_wdata;
    logic [31:0]  s_rdata;
    logic         s_rvalid;

    always #4 clk = ~clk;

    wide_reg_collector u_wide_reg_collector (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .rf_we(rf_we), .rf_re(rf_re), .rf_addr(rf_addr),
        .rf_size(rf_size), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
    );

    function automatic logic [31:0] pat(logic [15:0] a, logic [7:0] k, int d);
        return {k, 8'(d), a};
    endfunction

    always_comb
        for (int d = 0; d < 4; d++) rf_rdata[d*32 +: 32] = pat(rf_addr, key, d);

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] d);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        #2;
        s_we = rf_we; s_addr = rf_addr; s_size = rf_size; s_wdata = rf_wdata;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic rd(logic [15:0] a);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_addr = a;
        #2;
        s_re = rf_re; s_addr = rf_addr;
        @(negedge clk);
        host_req = 1'b0;
        s_rdata = host_rdata; s_rvalid = host_rvalid;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 rf_we idle", 128'(rf_we), 128'd0);
        chk("R1 rf_re idle", 128'(rf_re), 128'd0);
        chk("R1 rvalid idle", 128'(host_rvalid), 128'd0);
        key = 8'h11;
        rd(16'h0108);
        chk("R1 first read fetches", 128'(s_re), 128'd1);
        chk("R1 first read data", 128'(s_rdata), 128'(pat(16'h0100, 8'h11, 2)));
    endtask

    task automatic t_wide_write;
        wr(16'h0108, 32'hA2); chk("R2 no early commit", 128'(s_we), 0);
        wr(16'h0100, 32'hA0); chk("R2 no early commit", 128'(s_we), 0);
        wr(16'h010C, 32'hA3); chk("R2 no early commit", 128'(s_we), 0);
        wr(16'h0104, 32'hA1);
        chk("R2 commit", 128'(s_we), 1);
        chk("R2 addr", 128'(s_addr), 128'h0100);
        chk("R2 size", 128'(s_size), 2);
        chk("R2 data", s_wdata, {32'hA3, 32'hA2, 32'hA1, 32'hA0});
    endtask

    task automatic t_restart;
        wr(16'h0200, 32'hB0); wr(16'h0204, 32'hB1);
        wr(16'h0300, 32'hC0); chk("R3 restart no commit", 128'(s_we), 0);
        wr(16'h0208, 32'hD2); wr(16'h020C, 32'hD3);
        wr(16'h0200, 32'hD0); chk("R3 stale dwords not counted", 128'(s_we), 0);
        wr(16'h0204, 32'hD1);
        chk("R3 commit after restart", 128'(s_we), 1);
        chk("R3 data", s_wdata, {32'hD3, 32'hD2, 32'hD1, 32'hD0});
    endtask

    task automatic t_mem_write;
        wr(16'hC00C, 32'hE1); chk("R4 half no commit", 128'(s_we), 0);
        wr(16'hC008, 32'hE0);
        chk("R4 commit", 128'(s_we), 1);
        chk("R4 addr", 128'(s_addr), 128'hC008);
        chk("R4 size", 128'(s_size), 1);
        chk("R4 data", s_wdata, {64'b0, 32'hE1, 32'hE0});
    endtask

    task automatic t_read_snapshot;
        key = 8'h21;
        rd(16'h0100);
        chk("R5 dword0 fetch", 128'(s_re), 1);
        chk("R5 rvalid", 128'(s_rvalid), 1);
        chk("R5 data", 128'(s_rdata), 128'(pat(16'h0100, 8'h21, 0)));
        key = 8'h22;
        rd(16'h0108);
        chk("R6 no fetch", 128'(s_re), 0);
        chk("R6 snapshot data", 128'(s_rdata), 128'(pat(16'h0100, 8'h21, 2)));
        rd(16'h010C);
        chk("R6 snapshot data dw3", 128'(s_rdata), 128'(pat(16'h0100, 8'h21, 3)));
        rd(16'h0204);
        chk("R5 other register fetch", 128'(s_re), 1);
        chk("R5 other register data", 128'(s_rdata), 128'(pat(16'h0200, 8'h22, 1)));
    endtask

    task automatic t_mem_read;
        key = 8'h31;
        rd(16'hC010);
        chk("R7 low half fetch", 128'(s_re), 1);
        chk("R7 low half data", 128'(s_rdata), 128'(pat(16'hC010, 8'h31, 0)));
        key = 8'h32;
        rd(16'hC014);
        chk("R7 high half no fetch", 128'(s_re), 0);
        chk("R7 high half data", 128'(s_rdata), 128'(pat(16'hC010, 8'h31, 1)));
    endtask

    task automatic t_bell;
        wr(16'h0834, 32'hF1); chk("R8 low dword held", 128'(s_we), 0);
        wr(16'h083C, 32'hF3);
        chk("R8 top commits", 128'(s_we), 1);
        chk("R8 addr", 128'(s_addr), 128'h0830);
        chk("R8 merged zero fill", s_wdata, {32'hF3, 32'h0, 32'hF1, 32'h0});
        wr(16'h0A1C, 32'hF7);
        chk("R8 lone top", s_wdata, {32'hF7, 96'b0});
        wr(16'h0100, 32'h90);
        wr(16'h083C, 32'hF9);
        chk("R8 other collection zero fill", s_wdata, {32'hF9, 96'b0});
        wr(16'h0104, 32'h91); wr(16'h0108, 32'h92); wr(16'h010C, 32'h93);
        chk("R8 other collection survives", s_wdata, {32'h93, 32'h92, 32'h91, 32'h90});
    endtask

    task automatic t_bell_drop;
        wr(16'h0100, 32'h50); wr(16'h0104, 32'h51);
        wr(16'h2834, 32'h77); chk("R9 drop no commit", 128'(s_we), 0);
        wr(16'h0108, 32'h52); wr(16'h010C, 32'h53);
        chk("R9 kept collection", s_wdata, {32'h53, 32'h52, 32'h51, 32'h50});
        wr(16'h283C, 32'h78);
        chk("R9 dropped dword absent", s_wdata, {32'h78, 96'b0});
        chk("R11 page1 bell addr", 128'(s_addr), 128'h2830);
    endtask

    task automatic t_narrow;
        wr(16'h0100, 32'h60);
        wr(16'h6400, 32'h5A5A);
        chk("R10 narrow commit", 128'(s_we), 1);
        chk("R10 narrow size", 128'(s_size), 0);
        chk("R10 narrow addr", 128'(s_addr), 128'h6400);
        chk("R10 narrow data", s_wdata, {96'b0, 32'h5A5A});
        wr(16'h0104, 32'h61); wr(16'h0108, 32'h62); wr(16'h010C, 32'h63);
        chk("R10 collector untouched", s_wdata, {32'h63, 32'h62, 32'h61, 32'h60});
        key = 8'h41;
        rd(16'h0100);
        key = 8'h42;
        rd(16'h6400);
        chk("R10 narrow read fetch", 128'(s_re), 1);
        chk("R10 narrow read data", 128'(s_rdata), 128'(pat(16'h6400, 8'h42, 0)));
        rd(16'h0104);
        chk("R10 snapshot untouched", 128'(s_rdata), 128'(pat(16'h0100, 8'h41, 1)));
    endtask

    task automatic t_paging;
        wr(16'hAA1C, 32'hCC);
        chk("R11 page5 bell commit", 128'(s_we), 1);
        chk("R11 page5 bell addr", 128'(s_addr), 128'hAA10);
        wr(16'h0404, 32'hDD);
        chk("R11 non-narrow dword gathers", 128'(s_we), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset();
        t_wide_write();
        t_restart();
        t_mem_write();
        t_read_snapshot();
        t_mem_read();
        t_bell();
        t_bell_drop();
        t_narrow();
        t_paging();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule